// File: doc/BRIEF.md
# Manchester Line Receiver

This block turns one Manchester-coded serial line into a recovered bit clock and a recovered NRZ data stream. In this coding a `0` is a rise at the middle of the bit and a `1` is a fall at the middle of the bit, with an extra transition at the bit boundary whenever one is needed. The receiver does not look at which way the middle edge goes. It keeps a polarity register and XORs it with the line, so that every middle edge shows up as a rise on the recovered clock. Each rise starts a delay of three quarters of a bit. At the end of that delay the line is sampled inside the first half of the next bit, and the sampled level is the next data bit.

A clock-enable tick at 16 times the bit rate drives the delay. The line passes through a two-flop synchroniser before it is used. The delay counter holds itself busy, so edges at bit boundaries and short glitches in the middle of the delay are ignored. If the receiver first locks onto a boundary edge, for example when the first bit differs from the idle level, it realigns without help at the first pair of unequal bits. A one-cycle strobe marks each new data bit.

Top module: `mdec_rx`

## Requirements
- R1: While rst_ni is low, data_o and valid_o are 0. With the line held low, clk_rec_o is also 0 after reset.
- R2: clk_rec_o XOR data_o equals line_i as sampled two clk_i edges earlier (two-flop synchroniser, no other delay on that path).
- R3: A tick_i cycle that sees clk_rec_o high while the delay is idle starts the delay. The terminal count comes exactly 12 ticks later. Line activity during the delay is ignored, so two terminal counts are never less than 12 ticks apart.
- R4: At terminal count, data_o takes the synchronised line value (line_i from two edges before). After a 1 is taken, clk_rec_o follows the inverted line.
- R5: data_o changes only in the cycle where valid_o is high.
- R6: valid_o is a one-cycle pulse. It is raised by the edge of a tick_i cycle and appears together with the new data_o.
- R7: When the first bit matches the idle level, every later bit is recovered in order. This holds for a transmit bit period anywhere from 61 to 67 system clocks at a tick period of 4 clocks (about ±5 percent).
- R8: With the line idle low and a first bit of 1, all bits after the first pair of unequal adjacent bits are recovered correctly.
- R9: With the line idle high and a first bit of 0, all bits after the first pair of unequal adjacent bits are recovered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample enable, 16 per bit time |
| line_i | input | 1 | Raw Manchester line |
| data_o | output | 1 | Recovered NRZ data (polarity register) |
| clk_rec_o | output | 1 | Recovered clock, synchronised line XOR polarity |
| valid_o | output | 1 | One-cycle strobe when a new bit appears on data_o |

## Verification
Two things can fall in the same delay window: the terminal-count update of the polarity register and a new transition arriving on the line. The receiver must ignore the transition while the delay is busy and react only to rises seen once it is idle again. A directed glitch placed in the middle of the delay provokes this case. The bench judges it by the terminal count landing 49 to 52 clocks after the first visible rise, with the correct bit captured. Random streams with a skewed bit period then push boundary edges close to the end of the delay. Those streams are judged by the recovered bit sequence, aligned from its tail, against the transmitted bits.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic {DLY_IDLE = 1'b0, DLY_RUN = 1'b1} dly_state_e;

  // three quarters of a bit in oversample ticks
  function automatic int unsigned delay_ticks(input int unsigned os);
    return (os * 3) / 4;
  endfunction
endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdec_delay.sv
module mdec_delay #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic trig_i,
  output logic term_o
);
  import mdec_pkg::*;

  localparam int unsigned DLY = delay_ticks(OVERSAMPLE);
  localparam int unsigned CW  = $clog2(DLY + 1);

  dly_state_e     state_q;
  logic [CW-1:0]  cnt_q;

  // busy state holds the count after trig_i drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DLY_IDLE;
      cnt_q   <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        DLY_IDLE: begin
          if (trig_i) begin
            state_q <= DLY_RUN;
            cnt_q   <= CW'(DLY - 1);
          end
        end
        DLY_RUN: begin
          if (cnt_q == '0) state_q <= DLY_IDLE;
          else             cnt_q   <= cnt_q - CW'(1);
        end
        default: state_q <= DLY_IDLE;
      endcase
    end
  end

  assign term_o = (state_q == DLY_RUN) && tick_i && (cnt_q == '0);
endmodule

// File: rtl/mdec_pol.sv
module mdec_pol (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic term_i,
  input  logic smp_i,
  output logic pol_o,
  output logic valid_o
);
  logic pol_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= term_i;
      if (term_i) pol_q <= smp_i;
    end
  end

  assign pol_o   = pol_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/mdec_rx.sv
module mdec_rx #(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic data_o,
  output logic clk_rec_o,
  output logic valid_o
);
  logic line_s, pol, term, trig;

  mdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  // every mid-bit edge is seen as a rise here
  assign trig = line_s ^ pol;

  mdec_delay #(.OVERSAMPLE(OVERSAMPLE)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .trig_i(trig),
    .term_o(term)
  );

  mdec_pol u_pol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .term_i (term),
    .smp_i  (line_s),
    .pol_o  (pol),
    .valid_o(valid_o)
  );

  assign data_o    = pol;
  assign clk_rec_o = trig;
endmodule

// File: rtl/mdec_rx_chk.sv
module mdec_rx_chk #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic line_i,
  input logic data_o,
  input logic clk_rec_o,
  input logic valid_o
);
  localparam int unsigned DLY = (OVERSAMPLE * 3) / 4;

  logic [1:0] age_q;
  logic [5:0] tk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      tk_q  <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (valid_o)                  tk_q <= '0;
      else if (tick_i && tk_q != '1) tk_q <= tk_q + 6'd1;
    end
  end

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !data_o));

  assert_sync_path_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> ((clk_rec_o ^ data_o) == $past(line_i, 2)));

  assert_valid_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(tk_q) >= DLY));

  assert_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && age_q == 2'd3) |-> (data_o == $past(line_i, 3)));

  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && !$stable(data_o)) |-> valid_o);

  assert_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && age_q != 2'd0) |-> $past(tick_i));
endmodule

bind mdec_rx mdec_rx_chk #(.OVERSAMPLE(OVERSAMPLE)) u_chk (.*);

// File: tb/mdec_rx_tb_top.sv
`timescale 1ns/1ps
module mdec_rx_tb_top;
  localparam int TICK_DIV = 4;
  localparam int NBITS    = 32;
  localparam int MAXR     = 256;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, line_i = 1'b0;
  logic data_o, clk_rec_o, valid_o;

  int n_chk = 0, n_err = 0, cyc = 0, nrec = 0;
  bit done = 1'b0;
  bit rec [MAXR];
  bit bits [NBITS];

  mdec_rx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .line_i(line_i),
    .data_o(data_o), .clk_rec_o(clk_rec_o), .valid_o(valid_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int d = 0;
    forever begin
      @(negedge clk);
      d = (d + 1) % TICK_DIV;
      tick_i = (d == 0);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (valid_o && nrec < MAXR) begin
        rec[nrec] = data_o;
        nrec++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // level of the first half of a Manchester bit
  function automatic bit first_half(input bit b);
    return b;
  endfunction

  function automatic int first_pair();
    for (int i = 1; i < NBITS; i++) if (bits[i] != bits[i-1]) return i;
    return NBITS;
  endfunction

  task automatic wait_valid(output int t);
    int n = 0;
    do begin @(negedge clk); n++; end while (!valid_o && n < 400);
    t = cyc;
  endtask

  task automatic run_stream(input int mode, input bit idle, input bit b0);
    int per, h, p, bad, len;
    int pick;
    rst_ni = 1'b0;
    line_i = idle;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (100) @(negedge clk);
    nrec = 0;
    pick = $urandom % 3;
    per = (pick == 0) ? 61 : (pick == 1) ? 64 : 67;
    for (int i = 0; i < NBITS; i++) bits[i] = 1'($urandom);
    bits[0] = b0;
    bits[4] = ~bits[3];
    for (int i = 0; i < NBITS; i++) begin
      h = per / 2;
      line_i = first_half(bits[i]);
      repeat (h) @(negedge clk);
      line_i = ~first_half(bits[i]);
      repeat (per - h) @(negedge clk);
    end
    repeat (120) @(negedge clk);
    len = nrec;
    bad = 0;
    if (mode == 7) begin
      // correct start: whole stream after bit 0, plus one trailing idle sample
      chk(len == NBITS, "R7 count", len, NBITS);
      for (int k = 1; k < NBITS; k++)
        if (len - 1 - k >= 0 && rec[len-1-k] != bits[NBITS-k]) bad++;
      chk(bad == 0, "R7 bits", bad, 0);
    end else begin
      p = first_pair();
      for (int k = 1; k < NBITS - p; k++)
        if (len - 1 - k < 0 || rec[len-1-k] != bits[NBITS-k]) bad++;
      if (mode == 8) chk(bad == 0, "R8 bits", bad, 0);
      else           chk(bad == 0, "R9 bits", bad, 0);
    end
  endtask

  initial begin
    int t0, t1;
    $urandom(1234);
    repeat (5) @(negedge clk);
    chk(data_o == 1'b0, "R1 data", data_o, 0);
    chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(clk_rec_o == 1'b0, "R1 clk_rec", clk_rec_o, 0);

    line_i = 1'b1;
    @(negedge clk);
    chk(clk_rec_o == 1'b0, "R2 first stage", clk_rec_o, 0);
    @(negedge clk);
    chk(clk_rec_o == 1'b1, "R2 second stage", clk_rec_o, 1);
    t0 = cyc;
    repeat (18) @(negedge clk);
    line_i = 1'b0;                 // glitch inside the delay, R3
    repeat (6) @(negedge clk);
    line_i = 1'b1;
    wait_valid(t1);
    chk((t1 - t0) >= 49 && (t1 - t0) <= 52, "R3 delay", t1 - t0, 50);
    chk(data_o == 1'b1, "R4 sample one", data_o, 1);
    @(negedge clk);
    chk(valid_o == 1'b0, "R6 pulse", valid_o, 0);
    chk(clk_rec_o == 1'b0, "R4 inverted", clk_rec_o, 0);
    repeat (10) @(negedge clk);
    chk(data_o == 1'b1, "R5 hold", data_o, 1);

    line_i = 1'b0;
    repeat (2) @(negedge clk);
    t0 = cyc;
    wait_valid(t1);
    chk((t1 - t0) >= 49 && (t1 - t0) <= 52, "R3 delay zero", t1 - t0, 50);
    chk(data_o == 1'b0, "R4 sample zero", data_o, 0);

    for (int s = 0; s < 5; s++) run_stream(7, 1'b0, 1'b0);
    run_stream(8, 1'b0, 1'b1);
    run_stream(8, 1'b0, 1'b1);
    run_stream(9, 1'b1, 1'b0);
    run_stream(9, 1'b1, 1'b0);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) chk(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule